// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Execution Unit

This unit carries out the two reservation-based atomic operations of a 64-bit integer core: load-reserved and store-conditional, each in a 32-bit word form and a 64-bit doubleword form. The core hands it one decoded instruction at a time with a single-cycle `start` pulse. The pulse carries the instruction fields that pick the operation, the address register value and the store data. The unit accesses a synchronous single-port RAM window. It returns the destination-register value, a PC-advance strobe, or an exception with a cause code and a trap value, all on a one-cycle `done` strobe.

A single reservation is held as a valid bit plus the index of a fixed-size chunk of the RAM window. A load-reserved drops any old reservation and then sets a new one on the chunk it read. A store-conditional succeeds only while that reservation is valid and the store falls in the same chunk. Every store-conditional that does not trap clears the reservation. A snoop input reports writes made by other agents. Such a write into the reserved chunk kills the reservation.

The unit raises no exception when the reservation is missing or when the chunks do not match. The store-conditional just reports failure in the destination register.

Top module: `lrsc_unit`

## Requirements
- R1: After reset no `done`, `exc_valid` or `mem_req` is asserted and no reservation is held. A store-conditional issued first returns 1 and writes no memory.
- R2: The funct5 field selects the operation: 5'b00010 is load-reserved and 5'b00011 is store-conditional. The funct3 field selects the width: 3'b010 is the 32-bit word and 3'b011 is the 64-bit doubleword. Three cases raise cause 2 (illegal instruction) with trap value 0 and leave the reservation untouched: a load-reserved whose rs2 field is nonzero, any other funct5 value, and any other funct3 value.
- R3: Word forms need address bits [1:0] = 0 and doubleword forms need bits [2:0] = 0. A misaligned load-reserved raises cause 4 and a misaligned store-conditional raises cause 6. In both cases the trap value is the address. Misalignment takes priority over the range check.
- R4: An address below RAM_BASE, or at or above RAM_BASE + RAM_BYTES, raises cause 5 for a load-reserved and cause 7 for a store-conditional. The trap value is the address.
- R5: `done` is a one-cycle strobe. It comes 3 cycles after the start edge for a load-reserved that does not trap, 2 cycles after for a store-conditional that succeeds, and 1 cycle after for every other case. A doubleword load-reserved returns the full 64-bit RAM word at the address.
- R6: A word load-reserved returns the 32-bit half chosen by address bit 2 (1 = upper half), sign-extended to 64 bits.
- R7: A store-conditional with no valid reservation returns 1, writes no memory, and performs no alignment or range check. When a reservation is valid but the address lies in another chunk, it returns 1 and writes nothing. In both cases the reservation is left cleared.
- R8: A successful store-conditional writes rs2 to RAM and returns 0. The doubleword form writes all 8 byte lanes. The word form writes the low 32 bits of rs2 into the half chosen by address bit 2 (strobes 8'h0F or 8'hF0). The reservation is then cleared, so a repeat store-conditional returns 1.
- R9: The chunk index is (address − RAM_BASE) >> CHUNK_SHIFT. A store-conditional to any address in the reserved chunk can succeed.
- R10: A snoop write whose address falls in the reserved chunk clears the reservation. A snoop write to another chunk leaves it in place. When a load-reserved sets a reservation at the same edge as a snoop, the new reservation is kept.
- R11: An exception raises neither `rd_we` nor `pc_advance`. A store-conditional alignment or range fault keeps the reservation. A load-reserved alignment or range fault clears it.
- R12: A `start` pulse that arrives while an operation is still in progress is ignored.
- R13: `pc_advance` is asserted together with `done` for every operation that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to execute the presented instruction |
| funct5 | input | 5 | Operation-select field |
| funct3 | input | 3 | Width-select field |
| rs2_field | input | 5 | rs2 register index field (must be 0 for load-reserved) |
| rs1_val | input | 64 | Address operand |
| rs2_val | input | 64 | Store data operand |
| snoop_valid | input | 1 | Another agent writes memory this cycle |
| snoop_addr | input | 64 | Address of that foreign write |
| mem_req | output | 1 | RAM access request |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | RAM_AW | Byte offset into the RAM window |
| mem_wstrb | output | 8 | Byte-lane write strobes |
| mem_wdata | output | 64 | RAM write data |
| mem_rdata | input | 64 | RAM read data, valid the cycle after the read is sampled |
| done | output | 1 | Operation finished (one cycle) |
| rd_we | output | 1 | Destination-register write strobe |
| rd_data | output | 64 | Destination-register value |
| pc_advance | output | 1 | PC may move to the next instruction |
| exc_valid | output | 1 | Operation ended in an exception |
| exc_cause | output | 4 | Exception cause code |
| exc_tval | output | 64 | Exception trap value |

## Verification
The bench targets several corner cases, each paired with the fault a wrong design would show:
- Reservation lifetime. A store-conditional repeated after a success, an intervening snoop to the reserved chunk, or a faulting load-reserved must each fail. A design that forgets to clear the reservation would report 0 and corrupt RAM.
- Chunk granularity. A store-conditional to a different offset in the same chunk must still succeed. A store to the next chunk, or a snoop just past the chunk boundary, must be told apart from a hit. A design that compares exact addresses or slices the wrong bits would flip these outcomes.
- Trap ordering. A misaligned address below the RAM window must report misalignment, not an access fault. A store-conditional fault must keep the reservation alive. With no reservation, a misaligned store-conditional must not trap.
- Word forms. The bench checks upper-half sign extension and single-half byte strobes. A design that picks the wrong lane or zero-extends would return wrong values or overwrite the neighbouring word.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

   typedef enum logic [3:0] {
      CAUSE_ILLEGAL  = 4'd2,
      CAUSE_LD_MISAL = 4'd4,
      CAUSE_LD_FAULT = 4'd5,
      CAUSE_ST_MISAL = 4'd6,
      CAUSE_ST_FAULT = 4'd7
   } cause_e;

   localparam logic [4:0] F5_LOADRES   = 5'b00010;
   localparam logic [4:0] F5_STORECOND = 5'b00011;
   localparam logic [2:0] F3_WORD      = 3'b010;
   localparam logic [2:0] F3_DWORD     = 3'b011;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_CAPTURE,
      ST_WRITE
   } state_e;

   typedef struct packed {
      logic   legal;
      logic   is_sc;
      logic   dword;
      logic   fault;
      cause_e cause;
   } check_t;

endpackage

// File: rtl/lrsc_decode.sv
module lrsc_decode
   import lrsc_pkg::*;
#(
   parameter logic [63:0] RAM_BASE  = 64'h8000_0000,
   parameter int unsigned RAM_BYTES = 4096
) (
   input  logic [4:0]  funct5,
   input  logic [2:0]  funct3,
   input  logic [4:0]  rs2_field,
   input  logic [63:0] addr,
   output check_t      chk
);

   logic        width_ok, is_lr, is_sc, misal, outside;
   logic [63:0] offs;

   always_comb begin
      width_ok = (funct3 == F3_WORD) || (funct3 == F3_DWORD);
      is_lr    = (funct5 == F5_LOADRES) && width_ok && (rs2_field == 5'd0);
      is_sc    = (funct5 == F5_STORECOND) && width_ok;
      offs     = addr - RAM_BASE;
      misal    = (funct3 == F3_DWORD) ? (addr[2:0] != 3'd0) : (addr[1:0] != 2'd0);
      outside  = (addr < RAM_BASE) || (offs >= 64'(RAM_BYTES));

      chk.legal = is_lr || is_sc;
      chk.is_sc = is_sc;
      chk.dword = (funct3 == F3_DWORD);
      chk.fault = 1'b1;
      chk.cause = CAUSE_ILLEGAL;
      if (!(is_lr || is_sc)) begin
         chk.cause = CAUSE_ILLEGAL;
      end else if (misal) begin
         chk.cause = is_sc ? CAUSE_ST_MISAL : CAUSE_LD_MISAL;
      end else if (outside) begin
         chk.cause = is_sc ? CAUSE_ST_FAULT : CAUSE_LD_FAULT;
      end else begin
         chk.fault = 1'b0;
      end
   end

endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
   parameter logic [63:0] RAM_BASE    = 64'h8000_0000,
   parameter int unsigned RAM_BYTES   = 4096,
   parameter int unsigned CHUNK_SHIFT = 6,
   parameter bit          SNOOP_EN    = 1'b1,
   localparam int unsigned RAM_AW     = $clog2(RAM_BYTES),
   localparam int unsigned CHUNK_W    = RAM_AW - CHUNK_SHIFT
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_i,
   input  logic               clr_i,
   input  logic [CHUNK_W-1:0] chunk_i,
   input  logic               snoop_valid,
   input  logic [63:0]        snoop_addr,
   output logic               valid_o,
   output logic [CHUNK_W-1:0] chunk_o
);

   logic hit;

   generate
      if (SNOOP_EN) begin : g_snoop
         logic [63:0] s_off;
         assign s_off = snoop_addr - RAM_BASE;
         assign hit   = snoop_valid && valid_o && (snoop_addr >= RAM_BASE) &&
                        (s_off < 64'(RAM_BYTES)) &&
                        (s_off[RAM_AW-1:CHUNK_SHIFT] == chunk_o);
      end else begin : g_nosnoop
         logic unused_snoop;
         assign unused_snoop = snoop_valid ^ (^snoop_addr);
         assign hit          = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         chunk_o <= '0;
      end else if (set_i) begin
         valid_o <= 1'b1;
         chunk_o <= chunk_i;
      end else if (clr_i || hit) begin
         valid_o <= 1'b0;
      end
   end

   // R10: a snoop into the reserved chunk kills the reservation
   p_snoop_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !set_i) |=> !valid_o);

   // R7 / R8: a clear request always leaves no reservation behind
   p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !valid_o);

   // R10: a new reservation wins over a same-edge snoop
   p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> (valid_o && chunk_o == $past(chunk_i)));

endmodule

// File: rtl/lrsc_unit.sv
module lrsc_unit
   import lrsc_pkg::*;
#(
   parameter logic [63:0] RAM_BASE    = 64'h8000_0000,
   parameter int unsigned RAM_BYTES   = 4096,
   parameter int unsigned CHUNK_SHIFT = 6,
   parameter bit          SNOOP_EN    = 1'b1,
   localparam int unsigned RAM_AW     = $clog2(RAM_BYTES),
   localparam int unsigned CHUNK_W    = RAM_AW - CHUNK_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [4:0]        funct5,
   input  logic [2:0]        funct3,
   input  logic [4:0]        rs2_field,
   input  logic [63:0]       rs1_val,
   input  logic [63:0]       rs2_val,
   input  logic              snoop_valid,
   input  logic [63:0]       snoop_addr,
   output logic              mem_req,
   output logic              mem_we,
   output logic [RAM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wstrb,
   output logic [63:0]       mem_wdata,
   input  logic [63:0]       mem_rdata,
   output logic              done,
   output logic              rd_we,
   output logic [63:0]       rd_data,
   output logic              pc_advance,
   output logic              exc_valid,
   output logic [3:0]        exc_cause,
   output logic [63:0]       exc_tval
);

   generate
      if ((64'd1 << RAM_AW) != 64'(RAM_BYTES)) begin : g_bad_size
         $error("RAM_BYTES must be a power of two");
      end
      if (CHUNK_SHIFT < 3 || CHUNK_SHIFT >= RAM_AW) begin : g_bad_chunk
         $error("CHUNK_SHIFT must lie in [3, RAM_AW)");
      end
      if ((RAM_BASE & 64'(RAM_BYTES - 1)) != 64'd0) begin : g_bad_base
         $error("RAM_BASE must be aligned to RAM_BYTES");
      end
   endgenerate

   check_t             chk;
   state_e             state;
   logic [RAM_AW-1:0]  off;
   logic               accept, fault_now, res_valid, res_set, res_clr, sc_hit;
   logic [CHUNK_W-1:0] res_chunk;
   logic               op_dword, op_upper;
   logic [31:0]        half;

   lrsc_decode #(.RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES)) u_dec (
      .funct5(funct5), .funct3(funct3), .rs2_field(rs2_field),
      .addr(rs1_val), .chk(chk)
   );

   assign off       = RAM_AW'(rs1_val - RAM_BASE);
   assign accept    = start && (state == ST_IDLE);
   // a store-conditional only checks its address while a reservation exists
   assign fault_now = chk.fault && (!chk.legal || !chk.is_sc || res_valid);
   assign sc_hit    = res_valid && (res_chunk == off[RAM_AW-1:CHUNK_SHIFT]);
   assign res_set   = accept && chk.legal && !chk.is_sc && !chk.fault;
   assign res_clr   = accept && chk.legal &&
                      (chk.is_sc ? !fault_now : chk.fault);

   lrsc_resv #(
      .RAM_BASE(RAM_BASE), .RAM_BYTES(RAM_BYTES),
      .CHUNK_SHIFT(CHUNK_SHIFT), .SNOOP_EN(SNOOP_EN)
   ) u_resv (
      .clk(clk), .rst_n(rst_n), .set_i(res_set), .clr_i(res_clr),
      .chunk_i(off[RAM_AW-1:CHUNK_SHIFT]),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .valid_o(res_valid), .chunk_o(res_chunk)
   );

   assign half = op_upper ? mem_rdata[63:32] : mem_rdata[31:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         mem_addr   <= '0;
         mem_wstrb  <= '0;
         mem_wdata  <= '0;
         done       <= 1'b0;
         rd_we      <= 1'b0;
         rd_data    <= '0;
         pc_advance <= 1'b0;
         exc_valid  <= 1'b0;
         exc_cause  <= '0;
         exc_tval   <= '0;
         op_dword   <= 1'b0;
         op_upper   <= 1'b0;
      end else begin
         done       <= 1'b0;
         rd_we      <= 1'b0;
         pc_advance <= 1'b0;
         exc_valid  <= 1'b0;
         mem_req    <= 1'b0;
         mem_we     <= 1'b0;
         unique case (state)
            ST_IDLE: if (start) begin
               op_dword <= chk.dword;
               op_upper <= rs1_val[2];
               if (fault_now) begin
                  done      <= 1'b1;
                  exc_valid <= 1'b1;
                  exc_cause <= chk.cause;
                  exc_tval  <= chk.legal ? rs1_val : 64'd0;
               end else if (!chk.is_sc) begin
                  mem_req  <= 1'b1;
                  mem_addr <= off;
                  state    <= ST_READ;
               end else if (sc_hit) begin
                  mem_req   <= 1'b1;
                  mem_we    <= 1'b1;
                  mem_addr  <= off;
                  mem_wdata <= chk.dword ? rs2_val : {rs2_val[31:0], rs2_val[31:0]};
                  mem_wstrb <= chk.dword ? 8'hFF : (rs1_val[2] ? 8'hF0 : 8'h0F);
                  state     <= ST_WRITE;
               end else begin
                  done       <= 1'b1;
                  rd_we      <= 1'b1;
                  rd_data    <= 64'd1;
                  pc_advance <= 1'b1;
               end
            end
            ST_READ: state <= ST_CAPTURE;
            ST_CAPTURE: begin
               done       <= 1'b1;
               rd_we      <= 1'b1;
               pc_advance <= 1'b1;
               rd_data    <= op_dword ? mem_rdata : {{32{half[31]}}, half};
               state      <= ST_IDLE;
            end
            ST_WRITE: begin
               done       <= 1'b1;
               rd_we      <= 1'b1;
               pc_advance <= 1'b1;
               rd_data    <= 64'd0;
               state      <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R11: a trapping operation never writes rd nor advances the PC
   p_exc_no_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
      exc_valid |-> (!rd_we && !pc_advance));

   // R13: PC advance only accompanies a clean completion
   p_pc_with_done_r13: assert property (@(posedge clk) disable iff (!rst_n)
      pc_advance |-> (done && !exc_valid));

   // R8: a RAM write is followed by a success report
   p_sc_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_we) |=> (done && rd_we && rd_data == 64'd0));

   // R5: a RAM read completes two cycles later with a writeback
   p_lr_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we) |=> ##1 (done && rd_we));

   // R2: illegal encodings report a zero trap value
   p_illegal_tval_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_valid && exc_cause == CAUSE_ILLEGAL) |-> (exc_tval == 64'd0));

endmodule

// File: tb/lrsc_unit_test.sv
`timescale 1ns/1ps
module lrsc_unit_test;

   localparam logic [63:0] BASE  = 64'h8000_0000;
   localparam int          BYTES = 4096;
   localparam int          WORDS = BYTES / 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  funct5 = '0;
   logic [2:0]  funct3 = '0;
   logic [4:0]  rs2_field = '0;
   logic [63:0] rs1_val = '0, rs2_val = '0;
   logic        snoop_valid = 1'b0;
   logic [63:0] snoop_addr = '0;
   logic        mem_req, mem_we;
   logic [11:0] mem_addr;
   logic [7:0]  mem_wstrb;
   logic [63:0] mem_wdata;
   logic [63:0] mem_rdata = '0;
   logic        done, rd_we, pc_advance, exc_valid;
   logic [63:0] rd_data, exc_tval;
   logic [3:0]  exc_cause;

   int checks = 0;
   int failures = 0;

   always #2 clk = ~clk;

   lrsc_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .funct5(funct5), .funct3(funct3),
      .rs2_field(rs2_field), .rs1_val(rs1_val), .rs2_val(rs2_val),
      .snoop_valid(snoop_valid), .snoop_addr(snoop_addr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wstrb(mem_wstrb), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .rd_we(rd_we), .rd_data(rd_data), .pc_advance(pc_advance),
      .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval)
   );

   // RAM seen by the design, and the model's expected RAM
   logic [63:0] dmem [WORDS];
   logic [63:0] emem [WORDS];
   logic [63:0] wtmp;

   always @(posedge clk) begin
      if (mem_req) begin
         if (mem_we) begin
            wtmp = dmem[mem_addr[11:3]];
            for (int b = 0; b < 8; b++)
               if (mem_wstrb[b]) wtmp[b*8 +: 8] = mem_wdata[b*8 +: 8];
            dmem[mem_addr[11:3]] <= wtmp;
         end else begin
            mem_rdata <= dmem[mem_addr[11:3]];
         end
      end
   end

   // reference reservation state
   bit          m_rv = 0;
   logic [63:0] m_rc = '0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit mem_same();
      for (int i = 0; i < WORDS; i++)
         if (dmem[i] !== emem[i]) return 1'b0;
      return 1'b1;
   endfunction

   task automatic do_op(input string req, input logic [4:0] f5, input logic [2:0] f3,
                        input logic [4:0] r2f, input logic [63:0] addr,
                        input logic [63:0] data, input bit poke);
      bit is_lr, is_sc, dw, mis, oor, e_exc, timing_ok;
      logic [3:0]  e_cause;
      logic [63:0] e_tval, e_rd;
      logic [8:0]  idx;
      logic [31:0] w;
      int lat;
      is_lr = (f5 == 5'b00010) && (f3 == 3'b010 || f3 == 3'b011) && (r2f == 0);
      is_sc = (f5 == 5'b00011) && (f3 == 3'b010 || f3 == 3'b011);
      dw    = (f3 == 3'b011);
      mis   = dw ? (addr[2:0] != 0) : (addr[1:0] != 0);
      oor   = (addr < BASE) || (addr >= BASE + BYTES);
      idx   = 9'((addr - BASE) >> 3);
      e_exc = 0; e_cause = 0; e_tval = 0; e_rd = 0; lat = 1;
      if (!is_lr && !is_sc) begin
         e_exc = 1; e_cause = 4'd2; e_tval = 0;
      end else if (is_lr) begin
         if (mis || oor) begin
            e_exc = 1; e_cause = mis ? 4'd4 : 4'd5; e_tval = addr; m_rv = 0;
         end else begin
            lat = 3;
            w = addr[2] ? emem[idx][63:32] : emem[idx][31:0];
            e_rd = dw ? emem[idx] : {{32{w[31]}}, w};
            m_rv = 1; m_rc = (addr - BASE) >> 6;
         end
      end else begin
         if (!m_rv) begin
            e_rd = 1;
         end else if (mis || oor) begin
            e_exc = 1; e_cause = mis ? 4'd6 : 4'd7; e_tval = addr;
         end else if (((addr - BASE) >> 6) != m_rc) begin
            e_rd = 1; m_rv = 0;
         end else begin
            lat = 2; e_rd = 0; m_rv = 0;
            if (dw) emem[idx] = data;
            else if (addr[2]) emem[idx][63:32] = data[31:0];
            else emem[idx][31:0] = data[31:0];
         end
      end
      @(negedge clk);
      start = 1; funct5 = f5; funct3 = f3; rs2_field = r2f; rs1_val = addr; rs2_val = data;
      timing_ok = 1;
      for (int i = 1; i <= lat; i++) begin
         @(negedge clk);
         if (i == 1 && poke) begin
            // R12: a second request while busy, a store that would succeed
            start = 1; funct5 = 5'b00011; funct3 = 3'b011; rs2_field = 0;
            rs2_val = 64'hDEAD_BEEF_DEAD_BEEF;
         end else begin
            start = 0;
         end
         if (i < lat && done) timing_ok = 0;
      end
      chk(timing_ok && done, req, "done timing (R5)", {63'd0, done}, 64'd1);
      chk(exc_valid == e_exc, req, "exc_valid (R11)", {63'd0, exc_valid}, {63'd0, e_exc});
      if (e_exc) begin
         chk(exc_cause == e_cause, req, "exc_cause", {60'd0, exc_cause}, {60'd0, e_cause});
         chk(exc_tval == e_tval, req, "exc_tval", exc_tval, e_tval);
      end else begin
         chk(rd_data == e_rd, req, "rd_data", rd_data, e_rd);
      end
      chk(rd_we == !e_exc && pc_advance == !e_exc, req, "rd_we/pc_advance (R13)",
          {62'd0, rd_we, pc_advance}, {62'd0, !e_exc, !e_exc});
      chk(mem_same(), req, "RAM contents", 64'd0, 64'd0);
   endtask

   task automatic snoop(input logic [63:0] a);
      @(negedge clk);
      snoop_valid = 1; snoop_addr = a;
      if (m_rv && a >= BASE && a < BASE + BYTES && ((a - BASE) >> 6) == m_rc) m_rv = 0;
      @(negedge clk);
      snoop_valid = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      for (int i = 0; i < WORDS; i++) begin
         dmem[i] = {32'h9000_0000 + 32'(i), 32'h1000_0000 + 32'(i * 3)};
         emem[i] = dmem[i];
      end
      repeat (3) @(negedge clk);
      chk(!done && !mem_req && !exc_valid, "R1", "reset outputs",
          {61'd0, done, mem_req, exc_valid}, 64'd0);
      rst_n = 1;
      // R1 / R7: no reservation out of reset
      do_op("R1", 5'b00011, 3'b011, 0, BASE, 64'h1111, 0);
      // R5, R8: doubleword pair, then repeat fails
      do_op("R5", 5'b00010, 3'b011, 0, BASE + 64'h40, 0, 0);
      do_op("R8", 5'b00011, 3'b011, 0, BASE + 64'h40, 64'hA5A5_0123_4567_89AB, 0);
      do_op("R8", 5'b00011, 3'b011, 0, BASE + 64'h40, 64'h2222, 0);
      do_op("R5", 5'b00010, 3'b011, 0, BASE + 64'h40, 0, 0);
      // R6: word halves, sign extension
      do_op("R6", 5'b00010, 3'b010, 0, BASE + 64'h104, 0, 0);
      do_op("R6", 5'b00010, 3'b010, 0, BASE + 64'h100, 0, 0);
      // R9 / R8: same chunk, other offset, word store into low half
      do_op("R9", 5'b00011, 3'b010, 0, BASE + 64'h108, 64'hFFFF_FFFF_8765_4321, 0);
      do_op("R8", 5'b00010, 3'b010, 0, BASE + 64'h13C, 0, 0);
      do_op("R8", 5'b00011, 3'b010, 0, BASE + 64'h13C, 64'h0BAD_F00D, 0);
      // R7 / R9: other chunk fails and clears
      do_op("R7", 5'b00010, 3'b011, 0, BASE + 64'h200, 0, 0);
      do_op("R7", 5'b00011, 3'b011, 0, BASE + 64'h240, 64'h3333, 0);
      do_op("R7", 5'b00011, 3'b011, 0, BASE + 64'h200, 64'h4444, 0);
      // R10: snoop hit vs miss
      do_op("R10", 5'b00010, 3'b011, 0, BASE + 64'h300, 0, 0);
      snoop(BASE + 64'h338);
      do_op("R10", 5'b00011, 3'b011, 0, BASE + 64'h300, 64'h5555, 0);
      do_op("R10", 5'b00010, 3'b011, 0, BASE + 64'h300, 0, 0);
      snoop(BASE + 64'h340);
      do_op("R10", 5'b00011, 3'b011, 0, BASE + 64'h300, 64'h6666, 0);
      // R2: illegal encodings leave the reservation alone
      do_op("R2", 5'b00010, 3'b011, 0, BASE + 64'h400, 0, 0);
      do_op("R2", 5'b00010, 3'b011, 5'd1, BASE + 64'h400, 0, 0);
      do_op("R2", 5'b00001, 3'b011, 0, BASE + 64'h400, 0, 0);
      do_op("R2", 5'b00011, 3'b000, 0, BASE + 64'h400, 0, 0);
      do_op("R2", 5'b00011, 3'b011, 0, BASE + 64'h400, 64'h7777, 0);
      // R3 / R4: load faults
      do_op("R3", 5'b00010, 3'b010, 0, BASE + 2, 0, 0);
      do_op("R3", 5'b00010, 3'b011, 0, BASE + 4, 0, 0);
      do_op("R3", 5'b00010, 3'b010, 0, BASE - 2, 0, 0);
      do_op("R4", 5'b00010, 3'b011, 0, BASE - 8, 0, 0);
      do_op("R4", 5'b00010, 3'b011, 0, BASE + BYTES, 0, 0);
      // R3 / R4 / R11: store faults keep the reservation
      do_op("R11", 5'b00010, 3'b011, 0, BASE + 64'h600, 0, 0);
      do_op("R3", 5'b00011, 3'b011, 0, BASE + 4, 64'h8888, 0);
      do_op("R4", 5'b00011, 3'b010, 0, BASE + BYTES, 64'h8888, 0);
      do_op("R3", 5'b00011, 3'b010, 0, BASE + 64'h601, 64'h8888, 0);
      do_op("R11", 5'b00011, 3'b011, 0, BASE + 64'h600, 64'h9999_0000_1234_5678, 0);
      // R7: no reservation means no address check
      do_op("R7", 5'b00011, 3'b011, 0, BASE + 4, 64'hAAAA, 0);
      // R11: faulting load-reserved drops the reservation
      do_op("R11", 5'b00010, 3'b011, 0, BASE + 64'h500, 0, 0);
      do_op("R11", 5'b00010, 3'b011, 0, BASE + 64'h501, 0, 0);
      do_op("R11", 5'b00011, 3'b011, 0, BASE + 64'h500, 64'hBBBB, 0);
      // R12: start while busy is ignored
      do_op("R12", 5'b00010, 3'b011, 0, BASE + 64'h700, 0, 1);
      @(negedge clk);
      chk(!done && !mem_req, "R12", "no extra activity after busy start",
          {62'd0, done, mem_req}, 64'd0);
      do_op("R12", 5'b00011, 3'b011, 0, BASE + 64'h700, 64'hCCCC, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule